// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block replaces the software routine that brings a DDR3 memory out of power-up. It is a hardware state machine. It drives the phase-0 command, address and bank lines, together with the CKE, ODT and memory reset-control levels, that a command injector would otherwise drive. A one-cycle start pulse launches the sequence. The sequence raises the power-related controls and then raises CKE and waits a long settling time. Next it writes the four mode registers in the fixed order 2, 3, 1, 0. If the DLL-reset bit is set in the MR0 value, it writes MR0 a second time with that bit cleared. It ends with a ZQ calibration command.

The four 16-bit mode-register values are static inputs. The two delay units, long and short, are parameters counted in clock cycles, so a simulation build can shrink them. When the final wait ends, a done flag rises and stays high until reset. The main controller then takes over the memory lines.

Top module: `ddr3_init_seq`

## Requirements
- R1: Out of reset and before any start pulse, cke, odt, rstCtl, every command flag, addr, bank and done are all 0.
- R2: In the first cycle after a start pulse is sampled in idle, odt and rstCtl are 1, cke is 0, no command flag is set, and addr and bank are 0.
- R3: For the next LONG_CYC cycles cke is 1 with no command. From then until reset, cke, odt and rstCtl stay 1.
- R4: A command lasts exactly one cycle. Each command cycle is followed by at least one NOP cycle, in which all four flags (cmdCs, cmdRas, cmdCas, cmdWe, 1 = asserted) are 0 and addr and bank are 0.
- R5: A mode-register write sets all four command flags, puts the register value on addr and the register index on bank. The writes go MR2, MR3, MR1, MR0 in the cycles LONG_CYC+1, +3, +5 and +7 counted from the first cycle of R2.
- R6: If bit 8 of modeReg0 is 1, the NOP after the first MR0 write is followed by SHORT_CYC further NOP cycles. Then a second MR0 write is issued with addr equal to modeReg0 with bit 8 forced to 0, followed by one NOP. If bit 8 is 0, no second write occurs.
- R7: After the last MR0 write and its NOP, 6*SHORT_CYC NOP cycles pass. Then a ZQ calibration command is issued: cmdWe and cmdCs 1, cmdRas and cmdCas 0, addr 0x0400 (bit 10 set), bank 0.
- R8: After the ZQ command, 6*SHORT_CYC NOP cycles pass. Then done becomes 1 and stays 1, with no further commands, until reset.
- R9: A start pulse that arrives while the sequence runs, or after done, has no effect on any output.
- R10: Asserting reset in the middle of the sequence returns every output to the R1 state at once, and the block stays idle until a new start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Launches the sequence when sampled high in idle |
| modeReg0 | input | 16 | MR0 value; bit 8 is the DLL-reset flag |
| modeReg1 | input | 16 | MR1 value |
| modeReg2 | input | 16 | MR2 value |
| modeReg3 | input | 16 | MR3 value |
| cke | output | 1 | Clock enable level for the memory |
| odt | output | 1 | On-die termination control level |
| rstCtl | output | 1 | Memory reset-control level, 1 while the sequence owns the memory |
| cmdCs | output | 1 | Chip-select flag, 1 = asserted |
| cmdRas | output | 1 | RAS flag, 1 = asserted |
| cmdCas | output | 1 | CAS flag, 1 = asserted |
| cmdWe | output | 1 | WE flag, 1 = asserted |
| addr | output | 16 | Phase-0 address |
| bank | output | 3 | Phase-0 bank address |
| done | output | 1 | Sequence finished; sticky until reset |

## Verification
The bench builds the block with LONG_CYC = 5 and SHORT_CYC = 2, so one full sequence, including the optional second MR0 write and both six-unit waits, takes about forty cycles. Every output is compared against a cycle-exact model on every cycle. These small values make it practical to run several mode-register patterns with and without the DLL-reset bit. They also allow start pulses to be injected in the CKE wait, in the gap NOP and after done, and reset to be applied in the middle of the mode-register writes. The counter-load boundaries for all three wait lengths are therefore checked exactly.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  localparam int DLL_BIT = 8;
  localparam int ZQ_BIT  = 10;

  typedef enum logic [1:0] {
    WAIT_LONG = 2'd0,
    WAIT_DLL  = 2'd1,
    WAIT_POST = 2'd2
  } waitSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_CKEW, ST_MRCMD, ST_MRGAP,
    ST_DLLW, ST_POSTW, ST_ZQCMD, ST_ZQW, ST_DONE
  } seqState_e;

  typedef struct packed {
    logic       pwrOn;
    logic       ckeOn;
    logic       issueMr;
    logic       issueZq;
    logic       clrDll;
    logic [1:0] mrSel;
    logic       loadCnt;
    waitSel_e   waitSel;
    logic       seqDone;
  } seqStrobe_t;

endpackage

// File: rtl/ddr3_init_ctrl.sv
module ddr3_init_ctrl
  import ddr3_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       dllBit,
  input  logic       cntZero,
  output seqStrobe_t strobe
);

  localparam logic [2:0] LAST_MR = 3'd3;
  localparam logic [2:0] REDO_MR = 3'd4;

  seqState_e state, stateNxt;
  logic [2:0] step, stepNxt;

  // write order 2, 3, 1, 0; the repeat step is MR0 again
  function automatic logic [1:0] mrOfStep(input logic [2:0] s);
    case (s)
      3'd0:    return 2'd2;
      3'd1:    return 2'd3;
      3'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      state <= stateNxt;
      step  <= stepNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    stepNxt  = step;
    strobe   = '0;
    if (state != ST_IDLE && state != ST_PRE) strobe.ckeOn = 1'b1;
    if (state != ST_IDLE) strobe.pwrOn = 1'b1;
    case (state)
      ST_IDLE: if (startPulse) stateNxt = ST_PRE;
      ST_PRE: begin
        strobe.loadCnt = 1'b1;
        strobe.waitSel = WAIT_LONG;
        stateNxt       = ST_CKEW;
      end
      ST_CKEW: if (cntZero) begin
        stepNxt  = '0;
        stateNxt = ST_MRCMD;
      end
      ST_MRCMD: begin
        strobe.issueMr = 1'b1;
        strobe.mrSel   = mrOfStep(step);
        strobe.clrDll  = (step == REDO_MR);
        stateNxt       = ST_MRGAP;
      end
      ST_MRGAP: begin
        if (step < LAST_MR) begin
          stepNxt  = step + 3'd1;
          stateNxt = ST_MRCMD;
        end else if (step == LAST_MR && dllBit) begin
          strobe.loadCnt = 1'b1;
          strobe.waitSel = WAIT_DLL;
          stateNxt       = ST_DLLW;
        end else begin
          strobe.loadCnt = 1'b1;
          strobe.waitSel = WAIT_POST;
          stateNxt       = ST_POSTW;
        end
      end
      ST_DLLW: if (cntZero) begin
        stepNxt  = REDO_MR;
        stateNxt = ST_MRCMD;
      end
      ST_POSTW: if (cntZero) stateNxt = ST_ZQCMD;
      ST_ZQCMD: begin
        strobe.issueZq = 1'b1;
        strobe.loadCnt = 1'b1;
        strobe.waitSel = WAIT_POST;
        stateNxt       = ST_ZQW;
      end
      ST_ZQW:  if (cntZero) stateNxt = ST_DONE;
      ST_DONE: strobe.seqDone = 1'b1;
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ddr3_init_dp.sv
module ddr3_init_dp
  import ddr3_init_pkg::*;
#(
  parameter int LONG_CYC  = 250000,
  parameter int SHORT_CYC = 512,
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 3,
  parameter int CNT_W     = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] modeRegs [4],
  output logic              cntZero,
  output logic              cke,
  output logic              odt,
  output logic              rstCtl,
  output logic              cmdCs,
  output logic              cmdRas,
  output logic              cmdCas,
  output logic              cmdWe,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              done
);

  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_DLL   = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_POST  = CNT_W'(6 * SHORT_CYC - 1);
  localparam logic [ADDR_W-1:0] ZQ_ADDR   = ADDR_W'(1) << ZQ_BIT;

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] loadVal;
  logic [ADDR_W-1:0] mrVal;

  always_comb begin
    case (strobe.waitSel)
      WAIT_LONG: loadVal = LOAD_LONG;
      WAIT_DLL:  loadVal = LOAD_DLL;
      default:   loadVal = LOAD_POST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.loadCnt)   waitCnt <= loadVal;
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end

  assign cntZero = (waitCnt == '0);

  always_comb begin
    mrVal = modeRegs[strobe.mrSel];
    if (strobe.clrDll) mrVal[DLL_BIT] = 1'b0;
  end

  always_comb begin
    addr = '0;
    bank = '0;
    if (strobe.issueMr) begin
      addr = mrVal;
      bank = BANK_W'(strobe.mrSel);
    end else if (strobe.issueZq) begin
      addr = ZQ_ADDR;
    end
  end

  assign cmdCs  = strobe.issueMr | strobe.issueZq;
  assign cmdRas = strobe.issueMr;
  assign cmdCas = strobe.issueMr;
  assign cmdWe  = strobe.issueMr | strobe.issueZq;
  assign cke    = strobe.ckeOn;
  assign odt    = strobe.pwrOn;
  assign rstCtl = strobe.pwrOn;
  assign done   = strobe.seqDone;

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int LONG_CYC  = 250000,
  parameter int SHORT_CYC = 512,
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] modeReg0,
  input  logic [ADDR_W-1:0] modeReg1,
  input  logic [ADDR_W-1:0] modeReg2,
  input  logic [ADDR_W-1:0] modeReg3,
  output logic              cke,
  output logic              odt,
  output logic              rstCtl,
  output logic              cmdCs,
  output logic              cmdRas,
  output logic              cmdCas,
  output logic              cmdWe,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              done
);

  localparam int MAX_WAIT = (LONG_CYC > 6 * SHORT_CYC) ? LONG_CYC : 6 * SHORT_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  seqStrobe_t strobe;
  logic cntZero;
  logic [ADDR_W-1:0] modeRegs [4];

  assign modeRegs[0] = modeReg0;
  assign modeRegs[1] = modeReg1;
  assign modeRegs[2] = modeReg2;
  assign modeRegs[3] = modeReg3;

  ddr3_init_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .dllBit(modeReg0[DLL_BIT]), .cntZero(cntZero), .strobe(strobe)
  );

  ddr3_init_dp #(
    .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeRegs(modeRegs),
    .cntZero(cntZero), .cke(cke), .odt(odt), .rstCtl(rstCtl),
    .cmdCs(cmdCs), .cmdRas(cmdRas), .cmdCas(cmdCas), .cmdWe(cmdWe),
    .addr(addr), .bank(bank), .done(done)
  );

endmodule

// File: rtl/ddr3_init_chk.sv
module ddr3_init_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              odt,
  input logic              rstCtl,
  input logic              cmdCs,
  input logic              cmdRas,
  input logic              cmdCas,
  input logic              cmdWe,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              done
);

  localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << 10;

  AST_CKE_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rstN)
    cke |-> (odt && rstCtl)); // R2
  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> (cke && odt && rstCtl)); // R3
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdCs |=> !cmdCs); // R4
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cmdCs |-> (!cmdRas && !cmdCas && !cmdWe && addr == '0 && bank == '0)); // R4
  AST_MR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCs && cmdRas) |-> (cmdCas && cmdWe && cke)); // R5
  AST_MR3_AFTER_MR2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCs && cmdRas && bank == BANK_W'(3)) |-> ($past(cmdCs, 2) && $past(bank, 2) == BANK_W'(2))); // R5
  AST_ZQ_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCs && !cmdRas) |-> (cmdWe && !cmdCas && addr == ZQ_ADDR && bank == '0)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!cmdCs && cke)); // R8

endmodule

bind ddr3_init_seq ddr3_init_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) chk_i (
  .clk(clk), .rstN(rstN), .cke(cke), .odt(odt), .rstCtl(rstCtl),
  .cmdCs(cmdCs), .cmdRas(cmdRas), .cmdCas(cmdCas), .cmdWe(cmdWe),
  .addr(addr), .bank(bank), .done(done)
);

// File: tb/ddr3_init_seq_tb.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb_top;

  localparam int L = 5;
  localparam int S = 2;
  localparam int T_END = L + 13 * S + 16;
  localparam logic [15:0] NO_RESTART = 16'hFFFF;

  // row: modeReg0, modeReg1, modeReg2, modeReg3, cycle of an extra start pulse (R9)
  localparam logic [79:0] VEC [4] = '{
    {16'h0520, 16'h0044, 16'h0008, 16'h0000, NO_RESTART},
    {16'h0420, 16'h0006, 16'h0010, 16'h0004, NO_RESTART},
    {16'hFFFF, 16'hAAAA, 16'h5555, 16'h1234, 16'd3},
    {16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'(L + 8)}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [15:0] modeReg0 = '0, modeReg1 = '0, modeReg2 = '0, modeReg3 = '0;
  logic cke, odt, rstCtl, cmdCs, cmdRas, cmdCas, cmdWe, done;
  logic [15:0] addr;
  logic [2:0] bank;

  int checkCnt = 0;
  int failCnt = 0;
  int cycCnt = 0;

  always #4 clk = ~clk;

  ddr3_init_seq #(.LONG_CYC(L), .SHORT_CYC(S)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .modeReg0(modeReg0), .modeReg1(modeReg1), .modeReg2(modeReg2), .modeReg3(modeReg3),
    .cke(cke), .odt(odt), .rstCtl(rstCtl), .cmdCs(cmdCs), .cmdRas(cmdRas),
    .cmdCas(cmdCas), .cmdWe(cmdWe), .addr(addr), .bank(bank), .done(done)
  );

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt == 100000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  function automatic logic [26:0] actVec();
    return {cke, odt, rstCtl, cmdCs, cmdRas, cmdCas, cmdWe, bank, addr, done};
  endfunction

  // Expected outputs t cycles after the start pulse was sampled (t = 0: first step).
  function automatic logic [26:0] expAt(input int t, input logic [15:0] m0, m1, m2, m3,
                                        output string tag);
    logic ck, pw, c, r, ca, w, dn;
    logic [2:0] b;
    logic [15:0] a;
    int p, off, idx;
    {ck, pw, c, r, ca, w, dn} = '0;
    b = '0;
    a = '0;
    tag = "R1";
    if (t >= 0) begin
      pw = 1'b1;
      ck = (t >= 1);
      p = L + 9;
      if (t == 0) tag = "R2";
      else if (t <= L) tag = "R3";
      else if (t <= L + 8) begin
        off = t - L - 1;
        tag = "R4";
        if (off % 2 == 0) begin
          tag = "R5";
          idx = (off == 0) ? 2 : (off == 2) ? 3 : (off == 4) ? 1 : 0;
          {c, r, ca, w} = 4'hF;
          b = 3'(idx);
          a = (idx == 0) ? m0 : (idx == 1) ? m1 : (idx == 2) ? m2 : m3;
        end
      end else begin
        if (m0[8]) begin
          if (t <= p + S + 1) tag = "R6";
          if (t == p + S) begin
            {c, r, ca, w} = 4'hF;
            a = m0 & ~16'h0100;
          end
          p = p + S + 2;
        end
        if (t >= p) begin
          if (t <= p + 6 * S) tag = "R7";
          else tag = "R8";
          if (t == p + 6 * S) begin
            {c, w} = 2'b11;
            a = 16'h0400;
          end
          if (t > p + 12 * S) dn = 1'b1;
        end
      end
    end
    return {ck, pw, pw, c, r, ca, w, b, a, dn};
  endfunction

  task automatic checkVec(input string tag, input string what, input logic [26:0] expv);
    logic [26:0] got;
    got = actVec();
    checkCnt++;
    if (got !== expv) begin
      failCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, expv);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    startPulse = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    string tag;
    logic [26:0] e;

    // R1: reset state, no start
    doReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkVec("R1", "idle after reset", '0);
    end

    // table walk: full sequences, extra start pulses for R9
    for (int row = 0; row < 4; row++) begin
      doReset();
      {modeReg0, modeReg1, modeReg2, modeReg3} = VEC[row][79:16];
      @(negedge clk);
      checkVec("R1", "idle before start", '0);
      startPulse = 1'b1;
      for (int t = 0; t < T_END; t++) begin
        @(negedge clk);
        e = expAt(t, modeReg0, modeReg1, modeReg2, modeReg3, tag);
        checkVec(tag, $sformatf("row %0d cycle %0d", row, t), e);
        startPulse = (16'(t) == VEC[row][15:0]);
      end
      startPulse = 1'b0;
    end

    // R9: start after done has no effect
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    e = expAt(T_END, modeReg0, modeReg1, modeReg2, modeReg3, tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      checkVec("R9", "start after done", e);
    end

    // R10: reset in the middle of the mode-register writes
    doReset();
    modeReg0 = 16'h0520;
    startPulse = 1'b1;
    for (int t = 0; t <= L + 3; t++) begin
      @(negedge clk);
      startPulse = 1'b0;
    end
    e = expAt(L + 3, modeReg0, modeReg1, modeReg2, modeReg3, tag);
    checkVec("R5", "MR3 before mid-run reset", e);
    rstN = 1'b0;
    #1;
    checkVec("R10", "outputs during mid-run reset", '0);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < L + 6; i++) begin
      @(negedge clk);
      checkVec("R10", "idle after mid-run reset", '0);
    end

    // R10: restart after reset gives a fresh sequence
    startPulse = 1'b1;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      startPulse = 1'b0;
      e = expAt(t, modeReg0, modeReg1, modeReg2, modeReg3, tag);
      checkVec("R10", $sformatf("restart cycle %0d", t), e);
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule